// File: doc/BRIEF.md
# Masked Byte-Pattern Packet Filter

The block watches a received byte stream and decides, packet by packet, whether the opening bytes match either of two stored patterns. Each pattern covers up to 128 byte positions. A per-filter, per-position enable bit selects which positions are compared. Positions that are not enabled act as wildcards.

Software programs the patterns through a word-wide write port. A single value table holds both filters' bytes for each position. Two 128-bit enable vectors are loaded in 32-bit slices. The result comes out as a two-bit flag with a one-cycle qualifier. It is issued when the packet ends, or as soon as the last comparable position has gone by, whichever comes first.

Top module: `flex_pattern_filter`

## Requirements
- R1: After reset, `match_valid` and `match` are 0 and both enable vectors are cleared. A packet sent before any programming reports `match` = 00.
- R2: A write to register index 256 + 2*n (n = 0..127) stores the byte for filter 0 at position n from `cfg_wdata[7:0]` and the byte for filter 1 from `cfg_wdata[15:8]`. Odd indices in that range are ignored.
- R3: Register indices 0..3 load the filter 0 enable vector and indices 4..7 load the filter 1 vector. Word w covers bits 32w+31 down to 32w, and bit n enables position n.
- R4: A byte takes part in a filter's comparison only when that filter's enable bit for its position is 1. Bytes at positions that are not enabled have no effect on the result.
- R5: A filter reports 1 only if every enabled byte compared equal to its stored value.
- R6: A filter whose enable vector is all zero always reports 0.
- R7: If the packet ends before a filter's highest enabled position is received, that filter reports 0.
- R8: The byte carrying `in_sop` is position 0. An `in_sop` in the middle of a packet restarts the count, and the abandoned packet produces no result.
- R9: `match_valid` is high for exactly one cycle, in the cycle after the byte carrying `in_eop` is accepted. `match` holds the flags during that cycle and is 0 whenever `match_valid` is low.
- R10: When a packet reaches position 127, the result is issued one cycle after that byte. Any further bytes of the packet are ignored, and the later `in_eop` produces no second result.
- R11: Cycles with `in_valid` low are ignored, including any `in_sop`, `in_eop` or data on them. Valid bytes arriving outside a packet (after `in_eop`, before the next `in_sop`) are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register index |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | A byte is present this cycle |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_data | input | 8 | Packet byte |
| match_valid | output | 1 | One-cycle result qualifier |
| match | output | 2 | Per-filter match flag, bit f for filter f |

## Verification
The bench drives packets in which one enabled byte differs, and others in which only wildcard bytes differ. A design that ignores the enables, or swaps the two byte lanes of a table entry, flags the wrong filter. Packets that stop short of the last enabled position are included, so a design that only checks the bytes it actually saw reports a false match. A 128-byte run without an end marker expects the result before the end marker arrives and no second pulse after it. Further cases cover a restart in mid-packet, idle cycles carrying stray control bits, and writes to odd table indices. Each of these would show up as an extra or missing pulse, or as corrupted patterns.

// File: rtl/flex_pattern_filter.sv
module flex_pattern_filter #(
  parameter int NPOS  = 128,
  parameter int DW    = 8,
  parameter int NFLT  = 2,
  parameter int AW    = 10,
  parameter int CW    = 32,
  parameter int TBASE = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_wdata,
  input  logic            in_valid,
  input  logic            in_sop,
  input  logic            in_eop,
  input  logic [DW-1:0]   in_data,
  output logic            match_valid,
  output logic [NFLT-1:0] match
);
  localparam int PW     = $clog2(NPOS);
  localparam int MWORDS = NPOS / CW;
  localparam int RW     = NFLT * DW;

  logic [RW-1:0]                tbl [NPOS];
  logic [NFLT-1:0][NPOS-1:0]    mask_q;
  logic [PW-1:0]                pos_q;
  logic                         busy_q, done_q;
  logic [NFLT-1:0]              fail_q;

  logic [NFLT-1:0] fail_n, ok_n;
  logic [PW-1:0]   idx;
  logic [PW:0]     shamt;
  logic [RW-1:0]   row;
  logic            take, last, tbl_hit;
  logic [AW-1:0]   tbl_off;

  assign tbl_off = cfg_addr - AW'(TBASE);
  assign tbl_hit = cfg_we && (cfg_addr >= AW'(TBASE)) &&
                   (cfg_addr < AW'(TBASE + 2*NPOS)) && !cfg_addr[0];

  always_ff @(posedge clk)
    if (tbl_hit) tbl[tbl_off[PW:1]] <= cfg_wdata[RW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (cfg_we)
      for (int f = 0; f < NFLT; f++)
        for (int w = 0; w < MWORDS; w++)
          if (cfg_addr == AW'(f*MWORDS + w)) mask_q[f][w*CW +: CW] <= cfg_wdata;
  end

  assign take  = in_valid && (in_sop || (busy_q && !done_q));
  assign idx   = in_sop ? '0 : pos_q;
  assign shamt = {1'b0, idx} + (PW+1)'(1);
  assign row   = tbl[idx];
  assign last  = in_eop || (idx == PW'(NPOS-1));

  for (genvar f = 0; f < NFLT; f++) begin : g_flt
    assign fail_n[f] = (in_sop ? 1'b0 : fail_q[f]) |
                       (mask_q[f][idx] && (row[f*DW +: DW] != in_data));
    assign ok_n[f]   = !fail_n[f] && (|mask_q[f]) && ((mask_q[f] >> shamt) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q       <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= '0;
      match_valid <= 1'b0;
      match       <= '0;
    end else begin
      match_valid <= 1'b0;
      match       <= '0;
      if (take) begin
        pos_q  <= idx + PW'(1);
        fail_q <= fail_n;
        busy_q <= !in_eop;
        done_q <= last;
        if (last) begin
          match_valid <= 1'b1;
          match       <= ok_n;
        end
      end else if (in_valid && in_eop) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flex_pattern_filter_chk.sv
module flex_pattern_filter_chk #(
  parameter int NPOS = 128,
  parameter int NFLT = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_sop,
  input logic                      in_eop,
  input logic [NFLT-1:0][NPOS-1:0] mask_q,
  input logic                      match_valid,
  input logic [NFLT-1:0]           match
);
  p_quiet_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> (match == '0));

  p_one_byte_pkt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && in_eop) |=> match_valid);

  p_needs_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> $past(in_valid));

  for (genvar f = 0; f < NFLT; f++) begin : g_f
    p_empty_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (match_valid && match[f]) |-> ($past(mask_q[f]) != '0));
  end
endmodule

bind flex_pattern_filter flex_pattern_filter_chk #(.NPOS(NPOS), .NFLT(NFLT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
  .mask_q(mask_q), .match_valid(match_valid), .match(match));

// File: tb/flex_pattern_filter_tb.sv
`timescale 1ns/1ps
module flex_pattern_filter_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [9:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0]  in_data = 0;
  logic        match_valid;
  logic [1:0]  match;

  int total = 0, fails = 0, pulses = 0;
  logic [1:0] last_m = 0;
  logic [7:0] pkt [0:255];

  always #4 clk = ~clk;

  flex_pattern_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .match_valid(match_valid), .match(match));

  always @(negedge clk)
    if (match_valid) begin pulses++; last_m = match; end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); cfg_we = 1; cfg_addr = 10'(a); cfg_wdata = 32'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic build(int len);
    for (int i = 0; i < 256; i++) pkt[i] = 8'(i*7 + 3);
    for (int i = 0; i < 6; i++) pkt[i] = 8'(8'h10 + i);
    pkt[8] = 8'hA3; pkt[40] = 8'h5C; pkt[127] = 8'hEE;
    if (len < 0) pkt[0] = 0;
  endtask

  task automatic send(int len, bit gaps, bit sop1, bit eop_end);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = sop1 && (i == 0); in_eop = eop_end && (i == len-1);
      in_data = pkt[i];
      if (gaps) begin
        @(negedge clk);
        in_valid = 0; in_sop = 1; in_eop = 1; in_data = 8'hFF;
      end
    end
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 match_valid after reset", match_valid, 0);
    check("R1 match after reset", match, 0);
    build(48); pulses = 0;
    send(48, 0, 1, 1);
    check("R1 pulses unprogrammed", pulses, 1);
    check("R1 flags unprogrammed", last_m, 0);
  endtask

  task automatic program_all;
    for (int n = 0; n < 128; n++) wr(256 + 2*n, 0);
    for (int i = 0; i < 6; i++) wr(256 + 2*i, 8'h10 + i);
    wr(256 + 2*8, 16'hA300);
    wr(256 + 2*40, 16'h5C00);
    wr(256 + 2*127, 16'h00EE);
    wr(0, 32'h3F);
    wr(4, 32'h100);
    wr(5, 32'h100);
  endtask

  task automatic t_both;
    build(48); pulses = 0;
    send(48, 0, 1, 1);
    check("R9 single pulse", pulses, 1);
    check("R2 R3 R5 both match", last_m, 3);
  endtask

  task automatic t_masked_miss;
    build(48); pkt[4] = 8'h99; pulses = 0;
    send(48, 0, 1, 1);
    check("R5 enabled byte differs", last_m, 2);
    build(48); pkt[40] = 8'h00; pulses = 0;
    send(48, 0, 1, 1);
    check("R5 filter1 byte differs", last_m, 1);
  endtask

  task automatic t_unmasked;
    build(48); pkt[6] = 8'h00; pkt[20] = 8'h00; pkt[9] = 8'h00; pulses = 0;
    send(48, 0, 1, 1);
    check("R4 wildcard bytes differ", last_m, 3);
  endtask

  task automatic t_short;
    build(30); pulses = 0;
    send(30, 0, 1, 1);
    check("R7 short pulses", pulses, 1);
    check("R7 ends before pos 40", last_m, 1);
    build(6); pulses = 0;
    send(5, 0, 1, 1);
    check("R7 ends before pos 5", last_m, 0);
  endtask

  task automatic t_gaps;
    build(48); pulses = 0;
    send(48, 1, 1, 1);
    check("R11 gaps pulses", pulses, 1);
    check("R11 gaps flags", last_m, 3);
    for (int i = 0; i < 48; i++) pkt[i] = 8'h00;
    pulses = 0;
    send(10, 0, 0, 1);
    check("R11 bytes outside packet", pulses, 0);
  endtask

  task automatic t_restart;
    for (int i = 0; i < 256; i++) pkt[i] = 8'h00;
    pulses = 0;
    send(20, 0, 1, 0);
    build(48);
    send(48, 0, 1, 1);
    check("R8 restart pulses", pulses, 1);
    check("R8 restart flags", last_m, 3);
  endtask

  task automatic t_odd;
    wr(257, 32'hFFFF);
    wr(256 + 2*5 + 1, 32'h0);
    build(48); pulses = 0;
    send(48, 0, 1, 1);
    check("R2 odd index ignored", last_m, 3);
  endtask

  task automatic t_window;
    wr(3, 32'h8000_0000);
    build(200); pulses = 0;
    send(128, 0, 1, 0);
    check("R10 result before eop", pulses, 1);
    check("R10 flags at pos 127", last_m, 3);
    for (int i = 0; i < 256; i++) pkt[i] = 8'h00;
    send(40, 0, 0, 1);
    check("R10 no second pulse", pulses, 1);
    build(48); pkt[127] = 8'h01; pulses = 0;
    send(128, 0, 1, 1);
    check("R10 pos 127 compared", last_m, 2);
  endtask

  task automatic t_nomask;
    wr(4, 0); wr(5, 0);
    build(48); pulses = 0;
    send(128, 0, 1, 1);
    check("R6 filter1 empty mask", last_m, 1);
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    program_all;
    t_both;
    t_masked_miss;
    t_unmasked;
    t_short;
    t_gaps;
    t_restart;
    t_odd;
    t_window;
    t_nomask;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule